// File: doc/BRIEF.md
# Infix to Postfix Token Converter

This block reorders a stream of arithmetic tokens from the usual written order (operators between operands, with parentheses) into postfix order, where each operator follows all of its operands and no parentheses remain. It sits between a tokenizer and a stack-based evaluator. Operand tokens go straight to the output. Operators and open parentheses wait on an internal stack until precedence and associativity allow them to be emitted.

Tokens enter and leave through valid/ready handshakes. Each expression ends with an end token. On the end token the converter flushes its stack, forwards the end token, and is then ready for the next expression.

Two faults are detected: an operator stack that would exceed its depth, and parentheses that do not pair up. Either fault sets a sticky flag and halts the input until reset.

Top module: `i2p_converter`

## Requirements
- R1: A token is 9 bits. Bit 8 clear means an operand whose value is in bits 7:0. Bit 8 set means an operator whose code is in bits 7:0: 0x01 add, 0x02 subtract, 0x03 multiply, 0x04 power, 0x05 open parenthesis, 0x06 close parenthesis, 0xFF end (token 0x1FF). An operator token with any other code is consumed and produces no output.
- R2: Operands appear at the output in their arrival order. An accepted operand is presented on `out_data` in the next cycle whenever the output register is free.
- R3: Power ranks above multiply, and multiply ranks above add and subtract, which rank equally. An incoming add, subtract or multiply first emits every stacked operator of equal or higher rank.
- R4: Power is right-associative. An incoming power emits stacked operators of strictly higher rank only, so a stacked power stays on the stack.
- R5: A close parenthesis emits the stacked operators down to the nearest open parenthesis, and then both parentheses are discarded. The output never carries code 0x05 or 0x06.
- R6: On the end token the block emits all remaining stacked operators and then the end token 0x1FF. It then accepts the next expression.
- R7: A close parenthesis with no open parenthesis on the stack, or an open parenthesis still stacked when the end token is handled, sets `err_mismatch`. The flag stays set and `in_ready` stays low until reset.
- R8: With DEPTH entries stacked, any further push sets `err_overflow`. The flag stays set and `in_ready` stays low until reset. DEPTH pushes alone do not set it.
- R9: `in_ready` is low while stacked operators are being popped or drained. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.
- R10: After reset, `out_valid`, `err_overflow` and `err_mismatch` are low, `in_ready` is high, and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input token is valid |
| in_ready | output | 1 | Converter accepts the input token |
| in_data | input | 9 | Input token |
| out_valid | output | 1 | Output token is valid |
| out_ready | input | 1 | Consumer accepts the output token |
| out_data | output | 9 | Output token in postfix order |
| err_overflow | output | 1 | Sticky stack overflow flag |
| err_mismatch | output | 1 | Sticky unpaired parenthesis flag |

## Verification
A wrong stack pointer or a wrong precedence decision shows up at the ports as a misordered, missing or extra operator. This is seen no later than the end token of the same expression, and the scoreboard compares every emitted token. A lost open parenthesis or an over-count shows up as a mismatch or overflow flag within two cycles of the triggering token, and a halted `in_ready` follows at once. Backpressure patterns on `out_ready` show whether a stalled output token changes before it is accepted.

// File: rtl/i2p_pkg.sv
package i2p_pkg;
  localparam int TOK_W = 9;
  localparam int CODE_W = 8;

  localparam logic [CODE_W-1:0] OP_ADD = 8'h01;
  localparam logic [CODE_W-1:0] OP_SUB = 8'h02;
  localparam logic [CODE_W-1:0] OP_MUL = 8'h03;
  localparam logic [CODE_W-1:0] OP_POW = 8'h04;
  localparam logic [CODE_W-1:0] OP_LPAR = 8'h05;
  localparam logic [CODE_W-1:0] OP_RPAR = 8'h06;
  localparam logic [CODE_W-1:0] OP_END = 8'hFF;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_CMP,
    ST_PAR,
    ST_DRAIN,
    ST_HALT
  } conv_state_e;

  // binding strength; zero for anything that never pops on precedence
  function automatic logic [1:0] op_rank(input logic [CODE_W-1:0] code);
    case (code)
      OP_ADD, OP_SUB: op_rank = 2'd1;
      OP_MUL: op_rank = 2'd2;
      OP_POW: op_rank = 2'd3;
      default: op_rank = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/i2p_op_stack.sv
module i2p_op_stack #(
  parameter int DEPTH = 16,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         full
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp;
  logic [PW-1:0] sp_dec;

  assign sp_dec = sp - PW'(1);
  assign empty  = (sp == '0);
  assign full   = (sp == PW'(DEPTH));
  assign top    = mem[sp_dec[IW-1:0]];

  always_ff @(posedge clk) begin
    if (push) mem[sp[IW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) sp <= '0;
    else if (push) sp <= sp + PW'(1);
    else if (pop) sp <= sp_dec;
  end

  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_pop_empty_R5: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_push_pop_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(push && pop));
endmodule

// File: rtl/i2p_prec_cmp.sv
module i2p_prec_cmp
  import i2p_pkg::*;
(
  input  logic [CODE_W-1:0] stacked,
  input  logic [CODE_W-1:0] incoming,
  output logic              pop_first
);
  logic [1:0] r_s, r_i;

  always_comb begin
    r_s = op_rank(stacked);
    r_i = op_rank(incoming);
    // right-associative power keeps an equal-rank power stacked
    pop_first = (r_s != 2'd0) &&
                ((r_s > r_i) || ((r_s == r_i) && (incoming != OP_POW)));
  end
endmodule

// File: rtl/i2p_out_stage.sv
module i2p_out_stage #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         can_load
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (can_load) begin
      out_valid <= load;
      if (load) out_data <= load_data;
    end
  end

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  assert_load_when_free_R2: assert property (@(posedge clk) disable iff (rst)
    load |-> can_load);
endmodule

// File: rtl/i2p_converter.sv
module i2p_converter
  import i2p_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [TOK_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [TOK_W-1:0] out_data,
  output logic             err_overflow,
  output logic             err_mismatch
);
  conv_state_e       state, state_nx;
  logic [CODE_W-1:0] pend;
  logic [CODE_W-1:0] stk_top, push_code;
  logic              stk_empty, stk_full, do_push, do_pop;
  logic              pop_first, can_load, emit;
  logic [TOK_W-1:0]  emit_tok;
  logic              set_ovf, set_mis, take, is_op;
  logic [CODE_W-1:0] code;

  i2p_op_stack #(.DEPTH(DEPTH), .W(CODE_W)) u_stack (
    .clk(clk), .rst(rst), .push(do_push), .pop(do_pop), .wdata(push_code),
    .top(stk_top), .empty(stk_empty), .full(stk_full)
  );

  i2p_prec_cmp u_prec (.stacked(stk_top), .incoming(pend), .pop_first(pop_first));

  i2p_out_stage #(.W(TOK_W)) u_out (
    .clk(clk), .rst(rst), .load(emit), .load_data(emit_tok),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .can_load(can_load)
  );

  assign is_op    = in_data[TOK_W-1];
  assign code     = in_data[CODE_W-1:0];
  assign in_ready = (state == ST_RUN) && can_load;
  assign take     = in_valid && in_ready;

  always_comb begin
    state_nx  = state;
    do_push   = 1'b0;
    do_pop    = 1'b0;
    push_code = pend;
    emit      = 1'b0;
    emit_tok  = {1'b1, stk_top};
    set_ovf   = 1'b0;
    set_mis   = 1'b0;
    case (state)
      ST_RUN: if (take) begin
        if (!is_op) begin
          emit     = 1'b1;
          emit_tok = in_data;
        end else begin
          case (code)
            OP_LPAR: begin
              push_code = OP_LPAR;
              if (stk_full) begin
                set_ovf  = 1'b1;
                state_nx = ST_HALT;
              end else do_push = 1'b1;
            end
            OP_RPAR: state_nx = ST_PAR;
            OP_ADD, OP_SUB, OP_MUL, OP_POW: state_nx = ST_CMP;
            OP_END: state_nx = ST_DRAIN;
            default: state_nx = ST_RUN;
          endcase
        end
      end
      ST_CMP: begin
        if (!stk_empty && pop_first) begin
          if (can_load) begin
            emit   = 1'b1;
            do_pop = 1'b1;
          end
        end else if (stk_full) begin
          set_ovf  = 1'b1;
          state_nx = ST_HALT;
        end else begin
          do_push  = 1'b1;
          state_nx = ST_RUN;
        end
      end
      ST_PAR: begin
        if (stk_empty) begin
          set_mis  = 1'b1;
          state_nx = ST_HALT;
        end else if (stk_top == OP_LPAR) begin
          do_pop   = 1'b1;
          state_nx = ST_RUN;
        end else if (can_load) begin
          emit   = 1'b1;
          do_pop = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (stk_empty) begin
          if (can_load) begin
            emit     = 1'b1;
            emit_tok = {1'b1, OP_END};
            state_nx = ST_RUN;
          end
        end else if (stk_top == OP_LPAR) begin
          set_mis  = 1'b1;
          state_nx = ST_HALT;
        end else if (can_load) begin
          emit   = 1'b1;
          do_pop = 1'b1;
        end
      end
      default: state_nx = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_RUN;
      pend         <= '0;
      err_overflow <= 1'b0;
      err_mismatch <= 1'b0;
    end else begin
      state <= state_nx;
      if (take && is_op) pend <= code;
      if (set_ovf) err_overflow <= 1'b1;
      if (set_mis) err_mismatch <= 1'b1;
    end
  end

  assert_halt_blocks_input_R7: assert property (@(posedge clk) disable iff (rst)
    (err_overflow || err_mismatch) |-> !in_ready);
  assert_mismatch_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    err_mismatch |=> err_mismatch);
  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    err_overflow |=> err_overflow);
  assert_no_paren_out_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data != {1'b1, OP_LPAR} && out_data != {1'b1, OP_RPAR}));
  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (do_pop || (emit && state != ST_RUN)) |-> !in_ready);
endmodule

// File: tb/i2p_converter_tb.sv
`timescale 1ns/1ps
module i2p_converter_tb;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [8:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [8:0] out_data;
  logic       err_overflow, err_mismatch;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int bp_mode = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic       prev_stall = 1'b0;
  logic [8:0] prev_data = '0;

  localparam logic [8:0] T_ADD = 9'h101, T_SUB = 9'h102, T_MUL = 9'h103,
                         T_POW = 9'h104, T_LP = 9'h105, T_RP = 9'h106,
                         T_END = 9'h1FF;

  always #2.5 clk = ~clk;

  i2p_converter #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .err_overflow(err_overflow), .err_mismatch(err_mismatch)
  );

  function automatic logic [8:0] num(input int v);
    logic [7:0] b;
    b = v[7:0];
    return {1'b0, b};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_tok(input logic [8:0] t, input string req);
    exp_q.push_back(t);
    tag_q.push_back(req);
  endtask

  // monitor: backpressure pattern, scoreboard compare, stall-hold check
  always @(negedge clk) begin
    cyc++;
    case (bp_mode)
      1: out_ready = (cyc % 3) != 0;
      2: out_ready = (cyc % 5) < 2;
      default: out_ready = 1'b1;
    endcase
    #1;
    if (rst) prev_stall = 1'b0;
    else begin
      if (prev_stall) check("R9 hold", {out_valid, out_data} , {1'b1, prev_data});
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected token", out_data, 9'h000);
          if (out_data == 9'h000) begin
            failures++;
            $display("FAIL R2 extra token actual=%h expected=none", out_data);
          end
        end else begin
          check(tag_q.pop_front(), out_data, exp_q.pop_front());
        end
      end
    end
  end

  task automatic send(input logic [8:0] t);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = t;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic wait_drain(input string req);
    for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(req, 9'(exp_q.size()), 9'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R10 reset state
    check("R10 out_valid", {8'd0, out_valid}, 9'd0);
    check("R10 errors", {7'd0, err_overflow, err_mismatch}, 9'd0);
    check("R10 in_ready", {8'd0, in_ready}, 9'd1);

    // R2 R6: 3 + 4
    expect_tok(num(3), "R2"); expect_tok(num(4), "R2");
    expect_tok(T_ADD, "R6"); expect_tok(T_END, "R6");
    send(num(3)); send(T_ADD); send(num(4)); send(T_END);
    wait_drain("R6 drain");

    // R3: 2 + 3 * 4, with in_ready low during drain (R9)
    bp_mode = 1;
    expect_tok(num(2), "R3"); expect_tok(num(3), "R3"); expect_tok(num(4), "R3");
    expect_tok(T_MUL, "R3"); expect_tok(T_ADD, "R3"); expect_tok(T_END, "R6");
    send(num(2)); send(T_ADD); send(num(3)); send(T_MUL); send(num(4)); send(T_END);
    check("R9 ready low in drain", {8'd0, in_ready}, 9'd0);
    wait_drain("R3 drain");

    // R3 left associativity: 8 - 3 - 2
    expect_tok(num(8), "R3"); expect_tok(num(3), "R3"); expect_tok(T_SUB, "R3");
    expect_tok(num(2), "R3"); expect_tok(T_SUB, "R3"); expect_tok(T_END, "R6");
    send(num(8)); send(T_SUB); send(num(3)); send(T_SUB); send(num(2)); send(T_END);
    wait_drain("R3 left drain");

    // R4: 2 ^ 3 ^ 2
    bp_mode = 2;
    expect_tok(num(2), "R4"); expect_tok(num(3), "R4"); expect_tok(num(2), "R4");
    expect_tok(T_POW, "R4"); expect_tok(T_POW, "R4"); expect_tok(T_END, "R6");
    send(num(2)); send(T_POW); send(num(3)); send(T_POW); send(num(2)); send(T_END);
    wait_drain("R4 drain");

    // R3: 2 ^ 3 * 4
    expect_tok(num(2), "R3"); expect_tok(num(3), "R3"); expect_tok(T_POW, "R3");
    expect_tok(num(4), "R3"); expect_tok(T_MUL, "R3"); expect_tok(T_END, "R6");
    send(num(2)); send(T_POW); send(num(3)); send(T_MUL); send(num(4)); send(T_END);
    wait_drain("R3 pow-mul drain");

    // R5: 5 * ( 6 + 2 ^ 2 )
    bp_mode = 1;
    expect_tok(num(5), "R5"); expect_tok(num(6), "R5"); expect_tok(num(2), "R5");
    expect_tok(num(2), "R5"); expect_tok(T_POW, "R5"); expect_tok(T_ADD, "R5");
    expect_tok(T_MUL, "R5"); expect_tok(T_END, "R6");
    send(num(5)); send(T_MUL); send(T_LP); send(num(6)); send(T_ADD);
    send(num(2)); send(T_POW); send(num(2)); send(T_RP); send(T_END);
    wait_drain("R5 drain");

    // R1: undefined operator code 0x07 is dropped: 1 ?7 + 2
    bp_mode = 0;
    expect_tok(num(1), "R1"); expect_tok(num(2), "R1");
    expect_tok(T_ADD, "R1"); expect_tok(T_END, "R1");
    send(num(1)); send(9'h107); send(T_ADD); send(num(2)); send(T_END);
    wait_drain("R1 drain");
    check("R10 no error after valid runs", {7'd0, err_overflow, err_mismatch}, 9'd0);

    // R7: close parenthesis without open
    expect_tok(num(1), "R7");
    send(num(1)); send(T_RP);
    wait_drain("R7 drain a");
    check("R7 mismatch flag", {8'd0, err_mismatch}, 9'd1);
    check("R7 ready low", {8'd0, in_ready}, 9'd0);
    do_reset();

    // R7: open parenthesis left at end
    expect_tok(num(1), "R7");
    send(T_LP); send(num(1)); send(T_END);
    wait_drain("R7 drain b");
    check("R7 mismatch at end", {8'd0, err_mismatch}, 9'd1);
    check("R7 no overflow", {8'd0, err_overflow}, 9'd0);
    do_reset();
    @(negedge clk); #1;
    check("R10 flags cleared", {7'd0, err_overflow, err_mismatch}, 9'd0);

    // R8: DEPTH pushes fine, one more overflows
    for (int i = 0; i < DEPTH; i++) send(T_LP);
    repeat (2) @(negedge clk); #1;
    check("R8 full no overflow", {8'd0, err_overflow}, 9'd0);
    send(T_LP);
    repeat (2) @(negedge clk); #1;
    check("R8 overflow flag", {8'd0, err_overflow}, 9'd1);
    check("R8 ready low", {8'd0, in_ready}, 9'd0);
    do_reset();

    // R8: overflow on an operator push after DEPTH open parentheses
    for (int i = 0; i < DEPTH; i++) send(T_LP);
    expect_tok(num(9), "R8");
    send(num(9)); send(T_ADD);
    wait_drain("R8 drain");
    check("R8 overflow on operator", {8'd0, err_overflow}, 9'd1);
    do_reset();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule